// File: doc/BRIEF.md
# Message-Keyed TEA Chain Digest Checker

This block reads a contiguous span of memory and reduces it to a 64-bit integrity digest. It then compares the digest with an expected value supplied by its user. Every group of four consecutive 32-bit words becomes the 128-bit key of a 32-round TEA-style cipher. That cipher encrypts a two-word chaining value, and its output is folded back into that value with XOR. This is the Davies-Meyer construction, in which the message keys the cipher. The round sum is cleared once per scan and runs on across groups, so each group sees a different part of the sum sequence.

A boot controller pulses `start` with the span bounds and the expected digest. It waits while `busy` is high and then reads `pass` or `fail`. Only one of the two is set. Both hold until the next accepted start, so the controller can let execution proceed only on `pass`.

Top module: `tea_region_verifier`

## Requirements
- R1: While reset is applied and in the first cycle after it, `busy`, `pass`, `fail` and `mem_rd` are all low.
- R2: A `start` seen while `busy` is low latches `start_addr`, `end_addr` and `expect_hash`, and clears `pass` and `fail`. From the next cycle `busy` is high, and it stays high up to and including the cycle in which the comparison is made. A `start` seen while `busy` is high changes nothing: not the bounds, not the expected value, not the timing.
- R3: Reads go to ascending word addresses, 4 bytes apart, from `start_addr` up to the rounded end. Each address is read exactly once, and no address outside that span is strobed. `mem_rdata` must hold the word addressed by `mem_rd` in the cycle after the strobe.
- R4: The span length `end_addr - start_addr` is rounded down to a multiple of 16 bytes. A trailing part of fewer than 16 bytes is neither read nor hashed.
- R5: The chaining words start at w0 = 0x6D696368 and w1 = 0x61656C20 and the round sum starts at 0. Each 16-byte group gives k[0..3], the word at the lowest address being k[0]. The cipher starts from v0 = w0 and v1 = w1 and runs 32 rounds. One round does: v0 += (((v1<<4)^(v1>>5))+v1) ^ (sum+k[sum&3]); then sum += 0x9E3779B9; then v1 += (((v0<<4)^(v0>>5))+v0) ^ (sum+k[(sum>>11)&3]). The group ends with w0 ^= v0 and w1 ^= v1.
- R6: The round sum is not cleared between groups. The second group begins with the sum the first group left.
- R7: The digest is compared with `expect_hash`, whose bits [63:32] hold the expected w0 and bits [31:0] the expected w1. `pass` is set when both words match. `fail` is set when either word differs. The two are never high together.
- R8: Once set, `pass` or `fail` keeps its value until the next accepted start, and no reads are issued in that time.
- R9: If the rounded span is empty (`end_addr` not greater than `start_addr`, or less than 16 bytes above it), no read is issued. The initial w0 and w1 are compared directly, and `busy` is high for exactly one cycle.
- R10: Each 16-byte group takes 37 cycles: 4 strobes, a one-cycle tail for the last word, and 32 single-cycle rounds. Over N groups, `busy` is high for 37*N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (accepted only while idle) |
| start_addr | input | ADDR_W | First byte address of the span |
| end_addr | input | ADDR_W | Address one past the span (rounded down to a group boundary) |
| expect_hash | input | 64 | Expected digest, w0 in [63:32], w1 in [31:0] |
| mem_addr | output | ADDR_W | Read address |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 32 | Read data, valid the cycle after the strobe |
| busy | output | 1 | Scan or comparison in progress |
| pass | output | 1 | Digest matched the expected value |
| fail | output | 1 | Digest differed from the expected value |

## Verification
The bench goes after the places where a near miss still yields a plausible digest. A multi-group span catches a design that clears the round sum per group. A design that indexes the key with the wrong sum, before or after the delta, drifts from the bench's model of R5. Spans with an odd tail, and spans with the end at or below the start, expose wrong rounding: extra or missing reads, or a scan that never halts. Single-word corruptions of the expected value in each half prove that both words are compared. A second start during a scan, and a long idle gap after a result, show whether the latched inputs and the held verdict survive.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int WORD_W    = 32;
    localparam int KEY_WORDS = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [KEY_WORDS-1:0] key_t;

    localparam word_t TEA_DELTA = 32'h9E3779B9;
    localparam word_t CHAIN_IV0 = 32'h6D696368;
    localparam word_t CHAIN_IV1 = 32'h61656C20;
    // Chaining words 2 and 3 start at these values but never enter the digest.
    localparam word_t CHAIN_IV2 = 32'h676F7261;
    localparam word_t CHAIN_IV3 = 32'hFEDCBA98;

    typedef struct packed {
        word_t v0;
        word_t v1;
        word_t sum;
    } tea_lane_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ROUND,
        ST_CHECK
    } ctl_state_t;

    function automatic word_t tea_mix(input word_t x);
        return ((x << 4) ^ (x >> 5)) + x;
    endfunction

    function automatic tea_lane_t tea_step(input tea_lane_t in, input key_t k);
        tea_lane_t o;
        o.v0  = in.v0 + (tea_mix(in.v1) ^ (in.sum + k[in.sum[1:0]]));
        o.sum = in.sum + TEA_DELTA;
        o.v1  = in.v1 + (tea_mix(o.v0) ^ (o.sum + k[o.sum[12:11]]));
        return o;
    endfunction

endpackage

// File: rtl/tdm_fetch.sv
module tdm_fetch
    import tdm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] chunk_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  word_t             mem_rdata,
    output key_t              key,
    output logic              done
);

    localparam int ISS_W = $clog2(KEY_WORDS + 1);
    localparam int CAP_W = $clog2(KEY_WORDS);
    localparam int BYTES_PER_WORD = WORD_W / 8;

    logic [ISS_W-1:0] issue_cnt;
    logic [CAP_W-1:0] cap_cnt;
    logic             rd_q;
    word_t            word_q [KEY_WORDS];

    assign mem_rd   = en && (issue_cnt < ISS_W'(KEY_WORDS));
    assign mem_addr = chunk_addr + ADDR_W'(issue_cnt) * ADDR_W'(BYTES_PER_WORD);
    assign done     = rd_q && (cap_cnt == CAP_W'(KEY_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            issue_cnt <= '0;
            cap_cnt   <= '0;
            rd_q      <= 1'b0;
        end else begin
            rd_q <= mem_rd;
            if (mem_rd) issue_cnt <= issue_cnt + 1'b1;
            if (rd_q)   cap_cnt   <= cap_cnt + 1'b1;
        end
    end

    for (genvar i = 0; i < KEY_WORDS; i++) begin : g_key
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[i] <= '0;
            end else if (rd_q && cap_cnt == CAP_W'(i)) begin
                word_q[i] <= mem_rdata;
            end
        end
        assign key[i] = word_q[i];
    end

    // R3: the last word arrives only after every strobe of the group was issued
    assert_last_capture_after_strobes_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_rd);

endmodule

// File: rtl/tdm_round_core.sv
module tdm_round_core
    import tdm_pkg::*;
#(
    parameter int ROUNDS = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clear_sum,
    input  logic      load,
    input  logic      run,
    input  word_t     load_v0,
    input  word_t     load_v1,
    input  key_t      key,
    output tea_lane_t step_out,
    output logic      last
);

    localparam int CNT_W = $clog2(ROUNDS + 1);

    tea_lane_t        lane_q;
    logic [CNT_W-1:0] cnt;

    assign step_out = tea_step(lane_q, key);
    assign last     = run && (cnt == CNT_W'(ROUNDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= '0;
            cnt    <= '0;
        end else if (clear_sum) begin
            lane_q.sum <= '0;
            cnt        <= '0;
        end else if (load) begin
            lane_q.v0 <= load_v0;
            lane_q.v1 <= load_v1;
            cnt       <= '0;
        end else if (run) begin
            lane_q <= step_out;
            cnt    <= cnt + 1'b1;
        end
    end

    // R10: a group never runs past its round budget
    assert_round_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < CNT_W'(ROUNDS)));

    // R6: the sum survives a key load untouched
    assert_sum_kept_on_load_R6: assert property (@(posedge clk) disable iff (rst)
        (load && !clear_sum) |=> $stable(lane_q.sum));

endmodule

// File: rtl/tdm_compare.sv
module tdm_compare (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        eval,
    input  logic [63:0] digest,
    input  logic [63:0] expect_val,
    output logic        pass,
    output logic        fail
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pass <= 1'b0;
            fail <= 1'b0;
        end else if (eval) begin
            pass <= (digest == expect_val);
            fail <= (digest != expect_val);
        end
    end

    assert_verdict_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));

    assert_verdict_held_R8: assert property (@(posedge clk) disable iff (rst)
        (!clear && !eval) |=> ($stable(pass) && $stable(fail)));

endmodule

// File: rtl/tea_region_verifier.sv
module tea_region_verifier
    import tdm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ROUNDS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic [63:0]       expect_hash,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic              pass,
    output logic              fail
);

    localparam int CHUNK_BYTES = KEY_WORDS * WORD_W / 8;
    localparam logic [ADDR_W-1:0] CHUNK_STEP = ADDR_W'(CHUNK_BYTES);
    localparam logic [ADDR_W-1:0] CHUNK_MASK = ~(ADDR_W'(CHUNK_BYTES - 1));

    ctl_state_t        state;
    logic [ADDR_W-1:0] chunk_ptr;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] limit_q;
    logic [63:0]       expect_q;
    word_t             chain0;
    word_t             chain1;

    logic              accept;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] limit_nxt;
    logic [ADDR_W-1:0] ptr_nxt;
    logic              fetch_done;
    key_t              key;
    tea_lane_t         step_out;
    logic              round_last;

    assign accept    = start && (state == ST_IDLE);
    assign span      = end_addr - start_addr;
    assign limit_nxt = (end_addr > start_addr) ? (start_addr + (span & CHUNK_MASK)) : start_addr;
    assign ptr_nxt   = chunk_ptr + CHUNK_STEP;
    assign busy      = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            chunk_ptr <= '0;
            base_q    <= '0;
            limit_q   <= '0;
            expect_q  <= '0;
            chain0    <= '0;
            chain1    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        chunk_ptr <= start_addr;
                        base_q    <= start_addr;
                        limit_q   <= limit_nxt;
                        expect_q  <= expect_hash;
                        chain0    <= CHAIN_IV0;
                        chain1    <= CHAIN_IV1;
                        state     <= (limit_nxt == start_addr) ? ST_CHECK : ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (fetch_done) state <= ST_ROUND;
                end
                ST_ROUND: begin
                    if (round_last) begin
                        chain0    <= chain0 ^ step_out.v0;
                        chain1    <= chain1 ^ step_out.v1;
                        chunk_ptr <= ptr_nxt;
                        state     <= (ptr_nxt == limit_q) ? ST_CHECK : ST_FETCH;
                    end
                end
                ST_CHECK: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    tdm_fetch #(
        .ADDR_W(ADDR_W)
    ) fetch_i (
        .clk        (clk),
        .rst        (rst),
        .en         (state == ST_FETCH),
        .chunk_addr (chunk_ptr),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_rdata  (mem_rdata),
        .key        (key),
        .done       (fetch_done)
    );

    tdm_round_core #(
        .ROUNDS(ROUNDS)
    ) core_i (
        .clk       (clk),
        .rst       (rst),
        .clear_sum (accept),
        .load      (fetch_done),
        .run       (state == ST_ROUND),
        .load_v0   (chain0),
        .load_v1   (chain1),
        .key       (key),
        .step_out  (step_out),
        .last      (round_last)
    );

    tdm_compare cmp_i (
        .clk        (clk),
        .rst        (rst),
        .clear      (accept),
        .eval       (state == ST_CHECK),
        .digest     ({chain0, chain1}),
        .expect_val (expect_q),
        .pass       (pass),
        .fail       (fail)
    );

    assert_read_only_when_busy_R3: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> busy);

    assert_read_inside_span_R3: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> ((mem_addr >= base_q) && (mem_addr < limit_q)));

    assert_start_raises_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !pass && !fail));

    assert_busy_blocks_verdict_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!pass && !fail));

endmodule

// File: tb/tea_region_verifier_tb.sv
module tea_region_verifier_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [31:0] end_addr = '0;
    logic [63:0] expect_hash = '0;
    logic [31:0] mem_addr;
    logic        mem_rd;
    logic [31:0] mem_rdata = '0;
    logic        busy;
    logic        pass;
    logic        fail;

    int n_checks = 0;
    int n_fail   = 0;
    int cycle_no = 0;

    logic [31:0] exp_addr = '0;
    int          rd_count = 0;
    int          addr_err = 0;

    tea_region_verifier dut_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_addr  (start_addr),
        .end_addr    (end_addr),
        .expect_hash (expect_hash),
        .mem_addr    (mem_addr),
        .mem_rd      (mem_rd),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .pass        (pass),
        .fail        (fail)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h01000193) ^ 32'h811C9DC5 ^ (a >> 7);
    endfunction

    // Memory with one cycle of read latency
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem_word(mem_addr);
    end

    // Read-order monitor
    always @(negedge clk) begin
        if (mem_rd) begin
            if (mem_addr !== exp_addr) addr_err++;
            exp_addr = exp_addr + 32'd4;
            rd_count++;
        end
    end

    always @(posedge clk) begin
        cycle_no++;
        if (cycle_no > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 190000", cycle_no);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    function automatic logic [31:0] mix(input logic [31:0] x);
        return ((x << 4) ^ (x >> 5)) + x;
    endfunction

    function automatic logic [63:0] ref_digest(input logic [31:0] s, input logic [31:0] lim);
        logic [31:0] w0, w1, v0, v1, sum;
        logic [31:0] k [4];
        w0 = 32'h6D696368;
        w1 = 32'h61656C20;
        sum = 32'h0;
        for (logic [31:0] p = s; p != lim; p = p + 32'd16) begin
            for (int j = 0; j < 4; j++) k[j] = mem_word(p + 32'(4 * j));
            v0 = w0;
            v1 = w1;
            for (int r = 0; r < 32; r++) begin
                v0 = v0 + (mix(v1) ^ (sum + k[sum[1:0]]));
                sum = sum + 32'h9E3779B9;
                v1 = v1 + (mix(v0) ^ (sum + k[sum[12:11]]));
            end
            w0 = w0 ^ v0;
            w1 = w1 ^ v1;
        end
        return {w0, w1};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_hash(input logic [31:0] s, input logic [31:0] e, input logic [63:0] x,
                            input int inject_at, output int cyc);
        @(negedge clk);
        start_addr  = s;
        end_addr    = e;
        expect_hash = x;
        exp_addr    = s;
        rd_count    = 0;
        addr_err    = 0;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc   = 0;
        while (busy && cyc < 100000) begin
            cyc++;
            if (cyc == inject_at) begin
                start       = 1'b1;
                start_addr  = s + 32'h40;
                end_addr    = s + 32'h1000;
                expect_hash = ~x;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic t_reset();
        check(!busy && !pass && !fail && !mem_rd, "R1 outputs after reset",
              {60'h0, busy, pass, fail, mem_rd}, 64'h0);
    endtask

    task automatic t_single_group();
        int cyc;
        logic [63:0] d;
        d = ref_digest(32'h80000000, 32'h80000010);
        run_hash(32'h80000000, 32'h80000010, d, -1, cyc);
        check(pass && !fail, "R5 single group digest", {62'h0, pass, fail}, 64'h2);
        check(rd_count == 4 && addr_err == 0, "R3 single group reads", 64'(rd_count), 64'd4);
        check(cyc == 38, "R10 single group busy cycles", 64'(cyc), 64'd38);
        run_hash(32'h80000000, 32'h80000010, d ^ 64'h1, -1, cyc);
        check(!pass && fail, "R7 low word mismatch", {62'h0, pass, fail}, 64'h1);
        run_hash(32'h80000000, 32'h80000010, d ^ 64'h8000_0000_0000_0000, -1, cyc);
        check(!pass && fail, "R7 high word mismatch", {62'h0, pass, fail}, 64'h1);
    endtask

    task automatic t_carry_sum();
        int cyc;
        logic [63:0] d;
        d = ref_digest(32'h00001000, 32'h00001030);
        run_hash(32'h00001000, 32'h00001030, d, -1, cyc);
        check(pass && !fail, "R6 three groups with carried sum", {62'h0, pass, fail}, 64'h2);
        check(rd_count == 12 && addr_err == 0, "R3 three group reads", 64'(rd_count), 64'd12);
        check(cyc == 112, "R10 three group busy cycles", 64'(cyc), 64'd112);
    endtask

    task automatic t_round_down();
        int cyc;
        logic [63:0] d;
        d = ref_digest(32'h00002000, 32'h00002020);
        run_hash(32'h00002000, 32'h0000202C, d, -1, cyc);
        check(pass && !fail, "R4 tail ignored in digest", {62'h0, pass, fail}, 64'h2);
        check(rd_count == 8 && addr_err == 0, "R4 tail not read", 64'(rd_count), 64'd8);
    endtask

    task automatic t_empty();
        int cyc;
        logic [63:0] iv;
        iv = {32'h6D696368, 32'h61656C20};
        run_hash(32'h00003000, 32'h00003000, iv, -1, cyc);
        check(pass && !fail, "R9 equal bounds compares initial words", {62'h0, pass, fail}, 64'h2);
        check(rd_count == 0 && cyc == 1, "R9 equal bounds no reads, one busy cycle",
              {32'(rd_count), 32'(cyc)}, {32'd0, 32'd1});
        run_hash(32'h00003100, 32'h00003080, iv ^ 64'h10, -1, cyc);
        check(!pass && fail && rd_count == 0, "R9 end below start", {61'h0, pass, fail, rd_count != 0}, 64'h2);
        run_hash(32'h00003200, 32'h0000320C, iv, -1, cyc);
        check(pass && rd_count == 0 && cyc == 1, "R9 span under one group",
              {62'h0, pass, rd_count != 0}, 64'h2);
    endtask

    task automatic t_hold();
        int cyc;
        int seen_rd;
        logic [63:0] d;
        d = ref_digest(32'h00004000, 32'h00004020);
        run_hash(32'h00004000, 32'h00004020, d, -1, cyc);
        seen_rd = 0;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            if (mem_rd) seen_rd++;
        end
        check(pass && !fail && !busy && seen_rd == 0, "R8 verdict held while idle",
              {61'h0, pass, fail, seen_rd != 0}, 64'h4);
        @(negedge clk);
        start_addr = 32'h00004000;
        end_addr   = 32'h00004010;
        exp_addr   = 32'h00004000;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!pass && !fail && busy, "R8 new start clears verdict",
              {61'h0, pass, fail, busy}, 64'h1);
        while (busy) @(negedge clk);
    endtask

    task automatic t_start_ignored();
        int cyc;
        logic [63:0] d;
        d = ref_digest(32'h00005000, 32'h00005020);
        run_hash(32'h00005000, 32'h00005020, d, 10, cyc);
        check(pass && !fail, "R2 start during scan ignored (expected value)", {62'h0, pass, fail}, 64'h2);
        check(rd_count == 8 && addr_err == 0 && cyc == 75, "R2 start during scan ignored (span, timing)",
              {32'(rd_count), 32'(cyc)}, {32'd8, 32'd75});
    endtask

    task automatic t_default_span();
        int cyc;
        logic [63:0] d;
        d = ref_digest(32'h80000000, 32'h80004000);
        run_hash(32'h80000000, 32'h80004000, d, -1, cyc);
        check(pass && !fail, "R5 full default span digest", {62'h0, pass, fail}, 64'h2);
        check(rd_count == 4096 && addr_err == 0, "R3 full span reads", 64'(rd_count), 64'd4096);
        check(cyc == 37 * 1024 + 1, "R10 full span busy cycles", 64'(cyc), 64'(37 * 1024 + 1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_group();
        t_carry_sum();
        t_round_down();
        t_empty();
        t_hold();
        t_start_ignored();
        t_default_span();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule